// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block sits on the host side of a byte-wide parallel EEPROM. Software or an upstream engine issues a one-cycle start request with a starting address and a byte count. The bytes then arrive one at a time over a valid/ready handshake. For each byte, the sequencer drives the address and data lines, then asserts chip select, and then pulses the write strobe. Each bus phase is held for at least its minimum time, and every minimum is derived from nanosecond parameters and the clock period, rounded up to whole cycles.

Successive bytes step the low page-offset bits of the address and stay inside one page, so a whole page is loaded as one burst. Once the last byte is loaded, the device commits the page internally. The sequencer waits out the full write-cycle time before it reports completion and accepts a new request. If the upstream source stalls for too long in the middle of a burst, the sequencer closes the burst early, before the device's own byte-load window can expire. It then runs the same programming wait.

The output-enable line is kept inactive at all times, because the block only writes.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is asserted and while idle, `ee_cs_n_o`, `ee_we_n_o` and `ee_oe_n_o` are 1, and `busy_o` and `byte_ready_o` are 0.
- R2: A start accepted in idle latches `page_addr_i` and `count_i`. `count_i` holds the number of bytes minus one (0 means 1 byte, 127 means 128 bytes). Exactly that many write strobes follow, and `busy_o` stays 1 until the cycle after `done_o`.
- R3: Each write-strobe low pulse lasts `ceil(WP_NS*1000/CLK_PS)` cycles, and `ee_we_n_o` is low only while `ee_cs_n_o` is low. Chip select goes low at least `max(1, ceil(AS), ceil(DS) - pulse)` cycles before the strobe falls.
- R4: Address and data are stable from the fall of chip select until it rises again. After the strobe rises, chip select stays low for `max(1, ceil(DH), ceil(WPH), ceil(AH) - pulse)` cycles.
- R5: Between two strobes of one burst, the strobe stays high for at least the hold time plus the setup time plus one cycle.
- R6: Each byte after the first uses the previous address with the low `PAGE_BITS` bits incremented by one, wrapping modulo 2^PAGE_BITS. The upper bits stay unchanged.
- R7: `byte_ready_o` is 1 only while the block waits for a byte, never while chip select is low. A byte is taken on a clock edge where `byte_valid_i` and `byte_ready_o` are both 1, and the value on the bus is the accepted `byte_data_i`.
- R8: After at least one byte of a burst has been written, if no byte arrives for `STALL_CYC` consecutive wait cycles, the burst ends and programming begins. `STALL_CYC` is `max(1, ceil(BLC) - pulse - hold - setup - LOAD_MARGIN_CYC)`.
- R9: After the hold of the final byte, the block spends `ceil(WC_NS*1000/CLK_PS)` cycles programming. `done_o` is 1 during the last of those cycles only, and the block is idle on the next cycle.
- R10: `ee_oe_n_o` is 1 in every cycle.
- R11: A start request while busy is ignored and does not change the addresses of the running burst.
- R12: Before the first byte of a burst arrives, the block waits for it indefinitely, with no stall timeout and no programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| page_addr_i | input | ADDR_W | Address of the first byte |
| count_i | input | PAGE_BITS | Number of bytes minus one |
| byte_valid_i | input | 1 | Byte stream valid |
| byte_data_i | input | DATA_W | Byte stream data |
| byte_ready_o | output | 1 | Block is ready to take a byte |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse at the end of programming |
| ee_addr_o | output | ADDR_W | Memory address bus |
| ee_data_o | output | DATA_W | Memory data bus (write direction) |
| ee_cs_n_o | output | 1 | Chip select, active low |
| ee_we_n_o | output | 1 | Write strobe, active low |
| ee_oe_n_o | output | 1 | Output enable, active low, held inactive |

## Verification
The properties rely on two assumptions about the upstream side. `byte_valid_i` is held, with steady data, until the byte is accepted. A start request is only meaningful while the block is idle. The page-step property additionally assumes that the address seen at each strobe belongs to the current burst, and its burst flag clears whenever the block goes idle. The directed stimulus always drives inputs on the falling edge. It keeps each byte offered until the ready edge takes it. It issues starts while busy only to show that they are dropped. It chooses idle gaps either well below the stall limit or far beyond it, so the outcome does not depend on a single-cycle race with the timeout.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W          = 17,
  parameter int DATA_W          = 8,
  parameter int PAGE_BITS       = 7,
  parameter int CLK_PS          = 10000,
  parameter int AS_NS           = 0,
  parameter int AH_NS           = 100,
  parameter int DS_NS           = 100,
  parameter int DH_NS           = 10,
  parameter int WP_NS           = 150,
  parameter int WPH_NS          = 50,
  parameter int BLC_NS          = 150000,
  parameter int WC_NS           = 10000000,
  parameter int LOAD_MARGIN_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    page_addr_i,
  input  logic [PAGE_BITS-1:0] count_i,
  input  logic                 byte_valid_i,
  input  logic [DATA_W-1:0]    byte_data_i,
  output logic                 byte_ready_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [ADDR_W-1:0]    ee_addr_o,
  output logic [DATA_W-1:0]    ee_data_o,
  output logic                 ee_cs_n_o,
  output logic                 ee_we_n_o,
  output logic                 ee_oe_n_o
);

  function automatic longint ns2cyc(input longint ns);
    return (ns * 1000 + longint'(CLK_PS) - 1) / longint'(CLK_PS);
  endfunction

  function automatic longint lmax(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

  localparam int WP_CYC    = int'(lmax(1, ns2cyc(WP_NS)));
  localparam int SETUP_CYC = int'(lmax(1, lmax(ns2cyc(AS_NS), ns2cyc(DS_NS) - WP_CYC)));
  localparam int HOLD_CYC  = int'(lmax(lmax(1, ns2cyc(DH_NS)),
                                       lmax(ns2cyc(WPH_NS), ns2cyc(AH_NS) - WP_CYC)));
  localparam int STALL_CYC = int'(lmax(1, ns2cyc(BLC_NS) - WP_CYC - HOLD_CYC
                                          - SETUP_CYC - LOAD_MARGIN_CYC));
  localparam int WC_CYC    = int'(lmax(1, ns2cyc(WC_NS)));
  localparam int CNT_MAX   = int'(lmax(lmax(WP_CYC, SETUP_CYC),
                                       lmax(lmax(HOLD_CYC, STALL_CYC), WC_CYC)));
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SETUP, ST_PULSE, ST_HOLD, ST_PROG
  } state_t;

  state_t               state;
  logic [CNT_W-1:0]     timer;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    data_q;
  logic [PAGE_BITS-1:0] left_q;
  logic                 loaded_q;

  wire setup_end = timer == CNT_W'(SETUP_CYC - 1);
  wire pulse_end = timer == CNT_W'(WP_CYC - 1);
  wire hold_end  = timer == CNT_W'(HOLD_CYC - 1);
  wire stall_end = timer == CNT_W'(STALL_CYC - 1);
  wire prog_end  = timer == CNT_W'(WC_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      timer    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      left_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          addr_q   <= page_addr_i;
          left_q   <= count_i;
          loaded_q <= 1'b0;
          timer    <= '0;
          state    <= ST_WAIT;
        end
        ST_WAIT: if (byte_valid_i) begin
          data_q <= byte_data_i;
          timer  <= '0;
          state  <= ST_SETUP;
        end else if (loaded_q) begin
          if (stall_end) begin
            timer <= '0;
            state <= ST_PROG;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_SETUP: if (setup_end) begin
          timer <= '0;
          state <= ST_PULSE;
        end else begin
          timer <= timer + 1'b1;
        end
        ST_PULSE: if (pulse_end) begin
          timer <= '0;
          state <= ST_HOLD;
        end else begin
          timer <= timer + 1'b1;
        end
        ST_HOLD: if (hold_end) begin
          timer    <= '0;
          loaded_q <= 1'b1;
          if (left_q == '0) begin
            state <= ST_PROG;
          end else begin
            left_q <= left_q - 1'b1;
            addr_q <= {addr_q[ADDR_W-1:PAGE_BITS], addr_q[PAGE_BITS-1:0] + PAGE_BITS'(1)};
            state  <= ST_WAIT;
          end
        end else begin
          timer <= timer + 1'b1;
        end
        ST_PROG: if (prog_end) begin
          timer <= '0;
          state <= ST_IDLE;
        end else begin
          timer <= timer + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = state != ST_IDLE;
  assign byte_ready_o = state == ST_WAIT;
  assign done_o       = (state == ST_PROG) && prog_end;
  assign ee_cs_n_o    = !(state == ST_SETUP || state == ST_PULSE || state == ST_HOLD);
  assign ee_we_n_o    = state != ST_PULSE;
  assign ee_oe_n_o    = 1'b1;
  assign ee_addr_o    = addr_q;
  assign ee_data_o    = data_q;

endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 7,
  parameter int WP_CYC    = 1,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int WC_CYC    = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              byte_ready_o,
  input logic              ee_cs_n_o,
  input logic              ee_we_n_o,
  input logic [ADDR_W-1:0] ee_addr_o,
  input logic [DATA_W-1:0] ee_data_o
);

  int unsigned       lo_run, hi_run, cs_run;
  logic              in_burst;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run    <= 0;
      hi_run    <= 0;
      cs_run    <= 0;
      in_burst  <= 1'b0;
      prev_addr <= '0;
    end else begin
      lo_run <= ee_we_n_o ? 0 : lo_run + 1;
      if (!ee_we_n_o) hi_run <= 0;
      else if (hi_run != 32'hFFFF_FFFF) hi_run <= hi_run + 1;
      cs_run <= (!ee_cs_n_o && ee_we_n_o) ? cs_run + 1 : 0;
      if (!busy_o) in_burst <= 1'b0;
      else if ($fell(ee_we_n_o)) begin
        in_burst  <= 1'b1;
        prev_addr <= ee_addr_o;
      end
    end
  end

  p_we_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_we_n_o |-> !ee_cs_n_o);

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_we_n_o) |-> lo_run == WP_CYC);

  p_setup_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_we_n_o) |-> cs_run >= SETUP_CYC);

  p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_cs_n_o && $past(!ee_cs_n_o)) |-> ($stable(ee_addr_o) && $stable(ee_data_o)));

  p_hold_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs_n_o) |-> hi_run >= HOLD_CYC);

  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ee_we_n_o) && in_burst) |-> hi_run >= HOLD_CYC + SETUP_CYC);

  p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ee_we_n_o) && in_burst) |->
      (ee_addr_o[ADDR_W-1:PAGE_BITS] == prev_addr[ADDR_W-1:PAGE_BITS] &&
       ee_addr_o[PAGE_BITS-1:0] == prev_addr[PAGE_BITS-1:0] + PAGE_BITS'(1)));

  p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (busy_o && ee_cs_n_o));

  p_done_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hi_run >= HOLD_CYC + WC_CYC - 1 && ee_cs_n_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
  .WP_CYC(WP_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .WC_CYC(WC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .byte_ready_o(byte_ready_o), .ee_cs_n_o(ee_cs_n_o), .ee_we_n_o(ee_we_n_o),
  .ee_addr_o(ee_addr_o), .ee_data_o(ee_data_o)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int ADDR_W = 17, DATA_W = 8, PAGE_BITS = 7;
  localparam int E_WP = 15, E_SETUP = 1, E_HOLD = 5, E_STALL = 75, E_WC = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, byte_valid_i = 1'b0;
  logic [ADDR_W-1:0] page_addr_i = '0;
  logic [PAGE_BITS-1:0] count_i = '0;
  logic [DATA_W-1:0] byte_data_i = '0;
  logic byte_ready_o, busy_o, done_o, ee_cs_n_o, ee_we_n_o, ee_oe_n_o;
  logic [ADDR_W-1:0] ee_addr_o;
  logic [DATA_W-1:0] ee_data_o;

  always #5 clk = ~clk;

  eeprom_page_writer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .CLK_PS(10000),
    .AS_NS(0), .AH_NS(100), .DS_NS(100), .DH_NS(10), .WP_NS(145), .WPH_NS(50),
    .BLC_NS(1000), .WC_NS(2000), .LOAD_MARGIN_CYC(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_addr_i(page_addr_i),
    .count_i(count_i), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .byte_ready_o(byte_ready_o), .busy_o(busy_o), .done_o(done_o),
    .ee_addr_o(ee_addr_o), .ee_data_o(ee_data_o), .ee_cs_n_o(ee_cs_n_o),
    .ee_we_n_o(ee_we_n_o), .ee_oe_n_o(ee_oe_n_o)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;
  int n = 0, done_cnt = 0, unstable = 0, oe_bad = 0;
  longint last_rise = 0, done_cyc = 0;
  logic [ADDR_W-1:0] p_addr [128];
  logic [DATA_W-1:0] p_data [128];
  int p_width [128], p_lead [128], p_gap [128], p_hold [128];
  logic prev_we = 1'b1;
  int lowc = 0, highc = 0, csc = 0, holdc = 0;
  bit in_hold = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (!ee_oe_n_o) oe_bad++;
      if (done_o) begin done_cnt++; done_cyc = cyc; end
      if (prev_we && !ee_we_n_o && n < 128) begin
        p_addr[n] = ee_addr_o; p_data[n] = ee_data_o;
        p_lead[n] = csc; p_gap[n] = highc; n++;
      end
      if (!prev_we && !ee_we_n_o && n > 0 &&
          (ee_addr_o != p_addr[n-1] || ee_data_o != p_data[n-1])) unstable++;
      if (!prev_we && ee_we_n_o && n > 0) begin
        p_width[n-1] = lowc; last_rise = cyc; holdc = 0; in_hold = 1'b1;
      end
      if (in_hold) begin
        if (!ee_cs_n_o && ee_addr_o == p_addr[n-1] && ee_data_o == p_data[n-1]) holdc++;
        else if (ee_cs_n_o) begin p_hold[n-1] = holdc; in_hold = 1'b0; end
      end
      lowc  = ee_we_n_o ? 0 : lowc + 1;
      highc = ee_we_n_o ? highc + 1 : 0;
      csc   = (!ee_cs_n_o && ee_we_n_o) ? csc + 1 : 0;
      prev_we = ee_we_n_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    n = 0; done_cnt = 0; unstable = 0;
  endtask

  task automatic start_op(input logic [ADDR_W-1:0] a, input logic [PAGE_BITS-1:0] c);
    @(negedge clk); start_i = 1'b1; page_addr_i = a; count_i = c;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    @(negedge clk); byte_valid_i = 1'b1; byte_data_i = d;
    while (!byte_ready_o) @(negedge clk);
    @(negedge clk); byte_valid_i = 1'b0;
  endtask

  task automatic wait_done();
    while (done_cnt == 0) @(negedge clk);
    @(negedge clk);
    chk(!busy_o, "R9", "idle after done", busy_o, 0);
  endtask

  task automatic check_bytes(input logic [ADDR_W-1:0] base, input int cnt,
                             input logic [DATA_W-1:0] d0, input logic [DATA_W-1:0] step);
    chk(n == cnt, "R2", "strobe count", n, cnt);
    for (int i = 0; i < cnt && i < n; i++) begin
      logic [ADDR_W-1:0] ea;
      ea = {base[ADDR_W-1:PAGE_BITS], base[PAGE_BITS-1:0] + PAGE_BITS'(i)};
      chk(p_addr[i] == ea, "R6", "address", p_addr[i], ea);
      chk(p_data[i] == DATA_W'(d0 + i * step), "R7", "data", p_data[i], DATA_W'(d0 + i * step));
      chk(p_width[i] == E_WP, "R3", "strobe width", p_width[i], E_WP);
      chk(p_lead[i] == E_SETUP, "R3", "select lead", p_lead[i], E_SETUP);
      chk(p_hold[i] == E_HOLD, "R4", "hold cycles", p_hold[i], E_HOLD);
      if (i > 0) chk(p_gap[i] >= E_HOLD + E_SETUP + 1, "R5", "high gap", p_gap[i], E_HOLD + E_SETUP + 1);
    end
    chk(unstable == 0, "R4", "bus changes under strobe", unstable, 0);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
  endtask

  task automatic t_reset();
    chk(ee_cs_n_o && ee_we_n_o && ee_oe_n_o, "R1", "strobes in reset",
        {ee_cs_n_o, ee_we_n_o, ee_oe_n_o}, 7);
    chk(!busy_o && !byte_ready_o, "R1", "busy/ready in reset", {busy_o, byte_ready_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ee_cs_n_o && ee_we_n_o && !busy_o && !byte_ready_o, "R1", "idle outputs",
        {ee_cs_n_o, ee_we_n_o, busy_o, byte_ready_o}, 12);
  endtask

  task automatic t_basic();
    clear_mon();
    start_op(17'h0A345, 7'd3);
    chk(busy_o, "R2", "busy after start", busy_o, 1);
    push(8'hA1);
    start_op(17'h00000, 7'd0);
    push(8'hB2); push(8'hC3); push(8'hD4);
    wait_done();
    check_bytes(17'h0A345, 4, 8'hA1, 8'h11);
    chk(p_addr[1] == 17'h0A346, "R11", "start ignored while busy", p_addr[1], 17'h0A346);
    chk(done_cyc - last_rise == E_HOLD + E_WC - 1, "R9", "programming wait",
        done_cyc - last_rise, E_HOLD + E_WC - 1);
  endtask

  task automatic t_wrap();
    clear_mon();
    start_op(17'h1FF7E, 7'd2);
    push(8'h10); push(8'h20); push(8'h30);
    wait_done();
    check_bytes(17'h1FF7E, 3, 8'h10, 8'h10);
    chk(p_addr[2] == 17'h1FF00, "R6", "wrap inside page", p_addr[2], 17'h1FF00);
  endtask

  task automatic t_stall();
    clear_mon();
    start_op(17'h00010, 7'd9);
    push(8'h01); push(8'h02);
    repeat (60) @(negedge clk);
    push(8'h03);
    wait_done();
    check_bytes(17'h00010, 3, 8'h01, 8'h01);
    chk(done_cyc - last_rise == E_HOLD + E_STALL + E_WC - 1, "R8", "stall closes burst",
        done_cyc - last_rise, E_HOLD + E_STALL + E_WC - 1);
  endtask

  task automatic t_first_wait();
    clear_mon();
    start_op(17'h00123, 7'd0);
    repeat (400) @(negedge clk);
    chk(busy_o && byte_ready_o, "R12", "still waiting for first byte",
        {busy_o, byte_ready_o}, 3);
    chk(n == 0 && done_cnt == 0, "R12", "no strobe or done before first byte", n + done_cnt, 0);
    push(8'h5A);
    wait_done();
    check_bytes(17'h00123, 1, 8'h5A, 8'h00);
  endtask

  task automatic t_full();
    clear_mon();
    start_op(17'h04000, 7'd127);
    for (int i = 0; i < 128; i++) push(DATA_W'(8'h3C + i * 3));
    wait_done();
    check_bytes(17'h04000, 128, 8'h3C, 8'h03);
    chk(p_addr[127] == 17'h0407F, "R2", "last address of full page", p_addr[127], 17'h0407F);
    chk(oe_bad == 0, "R10", "output enable asserted cycles", oe_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_stall();
    t_first_wait();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule